// File: doc/BRIEF.md
# Flash Host-Programming Control Unit

This block is the flash control unit as an external programmer sees it while the chip sits in host programming mode. Mode entry happens when the chip reset pin is high and the program-store-enable pin is pulled low. While the mode lasts, the block keeps an internal oscillator enabled and holds the CPU core in reset. Commands are written with a falling edge on the program strobe. On that edge the block captures a 4-bit command code, a 16-bit address assembled from three port groups (2 + 6 + 8 bits) and an 8-bit data byte.

Program, chip-erase, lock-program and configuration-program commands are timed. They drive a ready/busy pin low for a fixed number of clocks. While that pin is low, the data port returns a polling byte in place of memory contents. The block also holds three security lock bits and two configuration bits. These bits can only be set, and only a chip erase clears them. A set lock bit disables byte-verify reads. The memory array is behavioural and its depth is a parameter. Addresses at or above that depth are unpopulated.

Top module: `flash_host_unit`

## Requirements
- R1: The mode is entered at a clock edge that samples `rstPin`=1 and `psenN`=0. From then on `oscEn`=1. The mode ends at the first edge that samples `rstPin`=0, and `oscEn` returns to 0 after that edge. `cpuRst` is 1 whenever `rstPin` is 1 or the mode is active.
- R2: After each mode entry, every command except read-ID (code 1) is ignored until a read-ID has been accepted. A read-ID loads the readback byte with the parameter `ID_CODE` (default A7h).
- R3: A strobe is sampled on the clock edge where `progN` is 0 after being 1. For a timed command, `readyBusy` falls right after that edge. It stays low for exactly `PROG_CYC` clocks (default 16) for byte program, lock program and configuration program, and for exactly `ERASE_CYC` clocks (default 64) for chip erase.
- R4: Byte program (code 3) stores old AND data. Byte-verify (code 2) loads the readback byte with the stored value. Unwritten bytes read FFh.
- R5: While a non-erase operation is busy, `dataOut` shows the complement of bit 3 of the last loaded data byte on bit 3, and 0 on every other bit. While a chip erase is busy, `dataOut` is 00h.
- R6: A strobe that arrives while `readyBusy` is 0 is ignored. It does not change memory or shorten or lengthen the busy time.
- R7: Codes 5, 6 and 7 set `lockBits[0]`, `lockBits[1]` and `lockBits[2]`. A lock bit never clears except by chip erase.
- R8: Codes 8 and 9 set `cfgBits[0]` and `cfgBits[1]`, which give the reset values of configuration register bits 0 and 1. These bits never clear except by chip erase.
- R9: While any lock bit is set, byte-verify loads 00h into the readback byte.
- R10: Chip erase (code 4) sets every byte to FFh and clears all lock and configuration bits.
- R11: Codes 0 and 10 to 15 are ignored. They start no busy period and leave the readback byte unchanged.
- R12: Addresses at or above `MEM_WORDS` are unpopulated. A program to such an address changes nothing, and a verify of it returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rstN | input | 1 | Power-on reset of the model, active low |
| rstPin | input | 1 | Chip reset pin, active high |
| psenN | input | 1 | Program-store-enable pin, low selects host mode |
| progN | input | 1 | Program strobe, falling edge starts a command |
| cmdIn | input | 4 | Command code |
| addrHi | input | 2 | Address bits 15:14 |
| addrMid | input | 6 | Address bits 13:8 |
| addrLo | input | 8 | Address bits 7:0 |
| dataIn | input | 8 | Data byte to load |
| dataOut | output | 8 | Readback byte, or polling byte while busy |
| readyBusy | output | 1 | 1 = ready, 0 = busy |
| oscEn | output | 1 | Internal oscillator enable |
| cpuRst | output | 1 | Holds the CPU core in reset |
| lockBits | output | 3 | Security lock bits |
| cfgBits | output | 2 | Configuration bits (reset values of config register bits 1:0) |

## Verification
The hardest situation to reach from the ports is a second strobe landing in the middle of a busy period. The bench has to time that strobe a known number of clocks after the first one, and then show that both the remaining busy count and the target byte are untouched. The stimulus does this with a program to a fresh address at a fixed offset into the busy window, followed by a verify of that address. The full memory is swept twice with two arithmetic patterns, so the AND rule is checked at every byte. The bench then sets the locks and configuration bits, erases the chip, and sweeps the memory again to confirm that every byte reads FFh.

// File: rtl/flash_host_pkg.sv
package flash_host_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_READ_ID = 4'd1,
    OP_VERIFY  = 4'd2,
    OP_PROGRAM = 4'd3,
    OP_ERASE   = 4'd4,
    OP_LOCK0   = 4'd5,
    OP_LOCK1   = 4'd6,
    OP_LOCK2   = 4'd7,
    OP_CFG0    = 4'd8,
    OP_CFG1    = 4'd9
  } opCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       loadId;
    logic       loadVerify;
    logic       commitProg;
    logic       commitErase;
    logic       setLock;
    logic       setCfg;
    logic [1:0] bitSel;
    logic       pollErase;
  } dpCtl_t;

endpackage

// File: rtl/flash_host_ctrl.sv
module flash_host_ctrl
  import flash_host_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPin,
  input  logic       psenN,
  input  logic       progN,
  input  logic [3:0] cmdIn,
  output logic       inMode,
  output logic       busy,
  output dpCtl_t     ctl
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             progQ;
  logic             idSeen;
  logic [CNT_W-1:0] busyCnt;
  opCode_t          pendOp;
  opCode_t          newOp;
  logic             progFall;
  logic             accept;
  logic             legal;
  logic             timed;
  logic [CNT_W-1:0] duration;
  logic             finish;

  assign progFall = progQ & ~progN;
  assign accept   = inMode & progFall & ~busy;
  assign newOp    = opCode_t'(cmdIn);
  assign legal    = accept & (idSeen | (newOp == OP_READ_ID));
  assign finish   = busy & (busyCnt == CNT_W'(1));

  always_comb begin
    timed    = 1'b0;
    duration = CNT_W'(PROG_CYC);
    case (newOp)
      OP_PROGRAM, OP_LOCK0, OP_LOCK1, OP_LOCK2, OP_CFG0, OP_CFG1: timed = 1'b1;
      OP_ERASE: begin
        timed    = 1'b1;
        duration = CNT_W'(ERASE_CYC);
      end
      default: timed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progQ   <= 1'b1;
      inMode  <= 1'b0;
      idSeen  <= 1'b0;
      busy    <= 1'b0;
      busyCnt <= '0;
      pendOp  <= OP_NONE;
    end else begin
      progQ <= progN;
      if (!rstPin) begin
        inMode <= 1'b0;
        idSeen <= 1'b0;
      end else if (!psenN) begin
        inMode <= 1'b1;
      end
      if (legal && newOp == OP_READ_ID) idSeen <= 1'b1;
      if (legal && timed) begin
        busy    <= 1'b1;
        busyCnt <= duration;
        pendOp  <= newOp;
      end else if (finish) begin
        busy    <= 1'b0;
        busyCnt <= '0;
      end else if (busy) begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.capture     = legal & timed;
    ctl.loadId      = legal & (newOp == OP_READ_ID);
    ctl.loadVerify  = legal & (newOp == OP_VERIFY);
    ctl.commitProg  = finish & (pendOp == OP_PROGRAM);
    ctl.commitErase = finish & (pendOp == OP_ERASE);
    ctl.setLock     = finish & (pendOp == OP_LOCK0 || pendOp == OP_LOCK1 || pendOp == OP_LOCK2);
    ctl.setCfg      = finish & (pendOp == OP_CFG0 || pendOp == OP_CFG1);
    case (pendOp)
      OP_LOCK1, OP_CFG1: ctl.bitSel = 2'd1;
      OP_LOCK2:          ctl.bitSel = 2'd2;
      default:           ctl.bitSel = 2'd0;
    endcase
    ctl.pollErase   = busy & (pendOp == OP_ERASE);
  end

  // R3
  busy_count_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt != '0));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && idSeen && timed) |=> busy);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && progFall && !finish) |=> ($stable(pendOp) && busy));

endmodule

// File: rtl/flash_host_dp.sv
module flash_host_dp
  import flash_host_pkg::*;
#(
  parameter int         MEM_WORDS = 256,
  parameter logic [7:0] ID_CODE   = 8'hA7
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic        busy,
  input  logic [15:0] addrIn,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  output logic [2:0]  lockBits,
  output logic [1:0]  cfgBits
);

  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [7:0]       mem [MEM_WORDS];
  logic [IDX_W-1:0] idx;
  logic             inRange;
  logic [IDX_W-1:0] latchIdx;
  logic             latchIn;
  logic [7:0]       latchData;
  logic [7:0]       rdback;

  assign idx     = addrIn[IDX_W-1:0];
  assign inRange = (addrIn >> IDX_W) == 16'd0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 8'hFF;
      lockBits  <= '0;
      cfgBits   <= '0;
      latchIdx  <= '0;
      latchIn   <= 1'b0;
      latchData <= '0;
      rdback    <= '0;
    end else begin
      if (ctl.capture) begin
        latchIdx  <= idx;
        latchIn   <= inRange;
        latchData <= dataIn;
      end
      if (ctl.loadId) rdback <= ID_CODE;
      if (ctl.loadVerify) begin
        if (|lockBits)    rdback <= 8'h00;
        else if (inRange) rdback <= mem[idx];
        else              rdback <= 8'hFF;
      end
      if (ctl.commitProg && latchIn) mem[latchIdx] <= mem[latchIdx] & latchData;
      if (ctl.setLock) lockBits[ctl.bitSel] <= 1'b1;
      if (ctl.setCfg)  cfgBits[ctl.bitSel[0]] <= 1'b1;
      if (ctl.commitErase) begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 8'hFF;
        lockBits <= '0;
        cfgBits  <= '0;
      end
    end
  end

  always_comb begin
    if (!busy)              dataOut = rdback;
    else if (ctl.pollErase) dataOut = 8'h00;
    else                    dataOut = {4'b0000, ~latchData[3], 3'b000};
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commitErase |=> ((lockBits & $past(lockBits)) == $past(lockBits)));

  // R8
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commitErase |=> ((cfgBits & $past(cfgBits)) == $past(cfgBits)));

  // R5
  poll_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(dataOut) <= 1 && dataOut[7:4] == 4'h0));

endmodule

// File: rtl/flash_host_unit.sv
module flash_host_unit
  import flash_host_pkg::*;
#(
  parameter int         MEM_WORDS = 256,
  parameter int         PROG_CYC  = 16,
  parameter int         ERASE_CYC = 64,
  parameter logic [7:0] ID_CODE   = 8'hA7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPin,
  input  logic       psenN,
  input  logic       progN,
  input  logic [3:0] cmdIn,
  input  logic [1:0] addrHi,
  input  logic [5:0] addrMid,
  input  logic [7:0] addrLo,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       readyBusy,
  output logic       oscEn,
  output logic       cpuRst,
  output logic [2:0] lockBits,
  output logic [1:0] cfgBits
);

  logic   inMode;
  logic   busy;
  dpCtl_t ctl;

  flash_host_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .rstPin(rstPin), .psenN(psenN), .progN(progN),
    .cmdIn(cmdIn), .inMode(inMode), .busy(busy), .ctl(ctl)
  );

  flash_host_dp #(.MEM_WORDS(MEM_WORDS), .ID_CODE(ID_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy),
    .addrIn({addrHi, addrMid, addrLo}), .dataIn(dataIn), .dataOut(dataOut),
    .lockBits(lockBits), .cfgBits(cfgBits)
  );

  assign readyBusy = ~busy;
  assign oscEn     = inMode;
  assign cpuRst    = rstPin | inMode;

  // R1
  mode_cpu_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscEn |-> cpuRst);

  // R1
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rstPin |=> !oscEn);

endmodule

// File: tb/flash_host_unit_test.sv
module flash_host_unit_test;

  logic       clk = 1'b0;
  logic       rstN, rstPin, psenN, progN;
  logic [3:0] cmdIn;
  logic [1:0] addrHi;
  logic [5:0] addrMid;
  logic [7:0] addrLo, dataIn;
  logic [7:0] dataOut;
  logic       readyBusy, oscEn, cpuRst;
  logic [2:0] lockBits;
  logic [1:0] cfgBits;

  int nChecks = 0;
  int nFails  = 0;

  localparam int PROG_N  = 16;
  localparam int ERASE_N = 64;

  always #2 clk = ~clk;

  flash_host_unit uut (
    .clk(clk), .rstN(rstN), .rstPin(rstPin), .psenN(psenN), .progN(progN),
    .cmdIn(cmdIn), .addrHi(addrHi), .addrMid(addrMid), .addrLo(addrLo),
    .dataIn(dataIn), .dataOut(dataOut), .readyBusy(readyBusy), .oscEn(oscEn),
    .cpuRst(cpuRst), .lockBits(lockBits), .cfgBits(cfgBits)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-clock low pulse on progN; returns at the negedge after the sampling edge
  task automatic strobe(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmdIn = c; {addrHi, addrMid, addrLo} = a; dataIn = d; progN = 1'b0;
    @(negedge clk);
    progN = 1'b1;
  endtask

  task automatic waitReady(output int cyc);
    cyc = 0;
    while (!readyBusy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic timedOp(input string req, input logic [3:0] c, input logic [15:0] a,
                         input logic [7:0] d, input int expCyc, input logic [7:0] expPoll);
    int cyc;
    strobe(c, a, d);
    chk({req, " poll"}, dataOut, expPoll);
    waitReady(cyc);
    chk({req, " busy"}, cyc, expCyc);
  endtask

  task automatic verify(input string req, input logic [15:0] a, input logic [7:0] exp);
    strobe(4'd2, a, 8'h00);
    chk(req, dataOut, exp);
  endtask

  function automatic logic [7:0] pat1(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat2(input int a);
    return 8'(a * 7 + 3);
  endfunction
  function automatic logic [7:0] pollOf(input logic [7:0] d);
    return {4'b0, ~d[3], 3'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    rstN = 1'b0; rstPin = 1'b0; psenN = 1'b1; progN = 1'b1;
    cmdIn = '0; {addrHi, addrMid, addrLo} = '0; dataIn = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset readyBusy", readyBusy, 1);
    chk("R1 reset oscEn", oscEn, 0);
    chk("R1 reset cpuRst", cpuRst, 0);
    chk("R7 reset locks", lockBits, 0);

    // R1 entry
    rstPin = 1'b1;
    @(negedge clk);
    chk("R1 cpuRst from pin", cpuRst, 1);
    chk("R1 no mode before psen", oscEn, 0);
    psenN = 1'b0;
    @(negedge clk);
    chk("R1 oscEn on entry", oscEn, 1);

    // R2 commands before read-ID are ignored
    strobe(4'd3, 16'h0010, 8'h00);
    chk("R2 program before id", readyBusy, 1);
    verify("R2 verify before id", 16'h0010, 8'h00);
    strobe(4'd1, 16'h0000, 8'h00);
    chk("R2 read-id", dataOut, 8'hA7);

    // R11 undefined codes
    for (int c = 10; c < 16; c++) begin
      strobe(4'(c), 16'h0001, 8'h00);
      chk("R11 undefined busy", readyBusy, 1);
      chk("R11 undefined readback", dataOut, 8'hA7);
    end
    strobe(4'd0, 16'h0001, 8'h00);
    chk("R11 code 0", readyBusy, 1);

    // R4 / R3 / R5 sweep: two patterns over every byte
    verify("R4 erased read", 16'h0042, 8'hFF);
    for (int a = 0; a < 256; a++) timedOp("R3 R5 prog1", 4'd3, 16'(a), pat1(a), PROG_N, pollOf(pat1(a)));
    for (int a = 0; a < 256; a++) verify("R4 pattern1", 16'(a), pat1(a));
    for (int a = 0; a < 256; a++) timedOp("R3 R5 prog2", 4'd3, 16'(a), pat2(a), PROG_N, pollOf(pat2(a)));
    for (int a = 0; a < 256; a++) verify("R4 and rule", 16'(a), pat1(a) & pat2(a));

    // R12 unpopulated addresses
    timedOp("R12 prog high", 4'd3, 16'h0105, 8'h00, PROG_N, 8'h08);
    verify("R12 alias untouched", 16'h0005, pat1(5) & pat2(5));
    verify("R12 high reads FF", 16'h0105, 8'hFF);
    verify("R12 top reads FF", 16'hC0FF, 8'hFF);

    // R6 strobe during busy is ignored
    strobe(4'd4, 16'h0000, 8'h00); // erase first so target bytes are FF
    waitReady(cyc);
    chk("R3 erase busy", cyc, ERASE_N);
    strobe(4'd3, 16'h0020, 8'h0F);
    repeat (4) @(negedge clk);
    strobe(4'd3, 16'h0021, 8'h00);
    waitReady(cyc);
    chk("R6 busy unchanged", cyc, PROG_N - 5 - 1);
    verify("R6 second byte untouched", 16'h0021, 8'hFF);
    verify("R6 first byte written", 16'h0020, 8'h0F);

    // R8 configuration bits
    timedOp("R8 cfg0", 4'd8, 16'h0000, 8'h00, PROG_N, 8'h08);
    chk("R8 cfg0 set", cfgBits, 2'b01);
    timedOp("R8 cfg1", 4'd9, 16'h0000, 8'h08, PROG_N, 8'h00);
    chk("R8 cfg both", cfgBits, 2'b11);

    // R7 / R9 locks
    verify("R9 verify open", 16'h0020, 8'h0F);
    timedOp("R7 lock0", 4'd5, 16'h0000, 8'h00, PROG_N, 8'h08);
    chk("R7 lock0 set", lockBits, 3'b001);
    verify("R9 verify locked", 16'h0020, 8'h00);
    timedOp("R7 lock1", 4'd6, 16'h0000, 8'h00, PROG_N, 8'h08);
    chk("R7 lock1 set", lockBits, 3'b011);
    timedOp("R7 lock2", 4'd7, 16'h0000, 8'h00, PROG_N, 8'h08);
    chk("R7 lock2 set", lockBits, 3'b111);
    timedOp("R7 program keeps locks", 4'd3, 16'h0030, 8'h00, PROG_N, 8'h08);
    chk("R7 locks held", lockBits, 3'b111);
    chk("R8 cfg held", cfgBits, 2'b11);

    // R10 chip erase
    timedOp("R10 R5 erase", 4'd4, 16'h0000, 8'hF7, ERASE_N, 8'h00);
    chk("R10 locks cleared", lockBits, 0);
    chk("R10 cfg cleared", cfgBits, 0);
    for (int a = 0; a < 256; a++) verify("R10 all FF", 16'(a), 8'hFF);

    // R1 exit and re-entry
    rstPin = 1'b0;
    @(negedge clk);
    chk("R1 oscEn off", oscEn, 0);
    chk("R1 cpuRst off", cpuRst, 0);
    rstPin = 1'b1;
    @(negedge clk);
    chk("R1 re-entry", oscEn, 1);
    strobe(4'd3, 16'h0001, 8'h00);
    chk("R2 id required again", readyBusy, 1);
    strobe(4'd1, 16'h0000, 8'h00);
    timedOp("R2 after id", 4'd3, 16'h0001, 8'h00, PROG_N, 8'h08);
    verify("R2 program landed", 16'h0001, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule